// File: doc/BRIEF.md
# Tile Background Scanline Renderer

This block turns a tile map and a set of 4-bit-per-pixel tile patterns into one scanline of background pixels. A pulse on `line_start` captures the scanline number, both scroll values and the left-column mask enable. The block then reads a 16-bit video memory through a simple synchronous read port. For each tile it reads one map word and two pattern words. It emits 256 consecutive pixels, and each pixel carries its colour index, palette select, priority flag and a 6-bit RGB value. The RGB value comes from an internal two-palette colour RAM.

The visible window is 256 by 192 pixels, cut from a 32 by 28 tile map. The horizontal scroll value is subtracted from the screen column and wraps at 256. The vertical scroll value is added to the scanline and wraps at 224. The map word for a tile is read in one 8-cycle slot, and that tile is shown in the next slot, so the pixel stream has no gaps. The colour RAM is loaded through a byte port whose 5-bit pointer advances after every data write.

Top module: `bg_render`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pix_valid` is 0 and `pix_x`, `pix_index`, `pix_pal`, `pix_prio` and `pix_rgb` are all 0. The colour RAM write pointer starts at 0 and every colour entry is 0.
- R2: Let the clock edge that samples `line_start` high be edge 0, with the block idle. Then `pix_valid` is high for exactly 256 consecutive cycles, starting in cycle 9 + ((256 - scroll_x) mod 8). `pix_x` counts 0 to 255 over those cycles.
- R3: The map word for screen pixel x sits at word address MAP_BASE + 32*row + col. Here col = ((x - scroll_x) mod 256) / 8 and row = ((line_num + scroll_y) mod 224) / 8.
- R4: A map word decodes as follows: bits 8:0 are the tile number, bit 9 is horizontal flip, bit 10 is vertical flip, bit 11 is the palette select and bit 12 is the priority flag. Bits 15:13 have no effect on any output.
- R5: Pattern row r of tile t occupies words 16*t + 2*r and 16*t + 2*r + 1. Plane 0 is the low byte of the first word, plane 1 its high byte, plane 2 the low byte of the second word and plane 3 its high byte. Bit n of the colour index comes from plane n.
- R6: Let fx = ((x - scroll_x) mod 256) mod 8. The block takes bit (7 - fx) of every plane, or bit fx when the horizontal flip bit is set.
- R7: Let fy = ((line_num + scroll_y) mod 224) mod 8. The block reads pattern row fy, or row 7 - fy when the vertical flip bit is set.
- R8: `pix_rgb` equals colour entry 16*`pix_pal` + `pix_index`, and it appears in the same cycle as that index.
- R9: When the mask enable was set at line start, pixels 0 to 7 come out with index 0, palette select 1, priority 0 and the RGB of colour entry 16.
- R10: `cram_addr_we` loads the pointer from `cram_wdata[4:0]`. `cram_data_we` stores `cram_wdata[5:0]` at the pointer and then advances the pointer, wrapping from 31 to 0. Bits 7:6 of the written byte are dropped. If both strobes are high in one cycle, only the pointer load takes place.
- R11: A colour write in the cycle that computes a pixel which uses the written entry leaves that pixel with the old colour. Pixels computed in later cycles show the new colour.
- R12: The block ignores a `line_start` pulse while a line is being produced, and ignores any change to the scroll, line or mask inputs after line start. The current line completes unchanged and no second line follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Starts a scanline when the block is idle |
| line_num | input | 8 | Screen line, 0 to 191 |
| scroll_x | input | 8 | Horizontal scroll, subtracted from the column |
| scroll_y | input | 8 | Vertical scroll, added to the line |
| mask_left | input | 1 | Hide the leftmost 8 pixels behind the backdrop colour |
| vram_rd_en | output | 1 | Read strobe to video memory |
| vram_addr | output | 13 | Word address to video memory |
| vram_rdata | input | 16 | Read data, valid the cycle after the strobe |
| cram_addr_we | input | 1 | Load the colour RAM pointer |
| cram_data_we | input | 1 | Write a colour entry and advance the pointer |
| cram_wdata | input | 8 | Pointer or colour byte |
| pix_valid | output | 1 | Pixel fields are valid |
| pix_x | output | 8 | Screen column of the pixel |
| pix_index | output | 4 | Colour index within the palette |
| pix_pal | output | 1 | Palette select |
| pix_prio | output | 1 | Priority-over-sprites flag |
| pix_rgb | output | 6 | Resolved colour, 2 bits each for blue, green and red |

## Verification
The colour lookup for the pixel being produced and a colour RAM write can take place in the same cycle. The bench provokes this during a line. It points the colour pointer at the entry used by a chosen pixel and asserts the data strobe in exactly the cycle that computes that pixel. The pixel that comes out next must carry the old colour, and every later pixel must carry the new one. In a second case, `line_start` and changed scroll values are applied in the middle of a line. The stream must stay identical to the undisturbed line and must stop after 256 pixels.

// File: rtl/bg_pkg.sv
package bg_pkg;

    localparam int WORD_W    = 16;
    localparam int COORD_W   = 8;
    localparam int IDX_W     = 4;
    localparam int RGB_W     = 6;
    localparam int CRAM_AW   = 5;
    localparam int CRAM_N    = 1 << CRAM_AW;
    localparam int TILE_PX   = 8;
    localparam int FINE_W    = $clog2(TILE_PX);
    localparam int MAP_COLS  = 32;
    localparam int COL_W     = $clog2(MAP_COLS);
    localparam int MAP_ROWS  = 28;
    localparam int ROW_W     = 5;
    localparam int V_WRAP    = MAP_ROWS * TILE_PX;
    localparam int TILES_VIS = 32;
    localparam int SLOT_LAST = TILES_VIS + 1;
    localparam int SLOT_W    = $clog2(SLOT_LAST + 1);
    localparam int SCREEN_W  = TILES_VIS * TILE_PX;
    localparam logic [CRAM_AW-1:0] BACKDROP = 5'd16;

    typedef struct packed {
        logic [2:0] spare;
        logic       prio;
        logic       pal;
        logic       vflip;
        logic       hflip;
        logic [8:0] tile;
    } map_ent_t;

    typedef struct packed {
        logic [7:0] p3;
        logic [7:0] p2;
        logic [7:0] p1;
        logic [7:0] p0;
    } tile_row_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             pal;
        logic             prio;
    } bg_pix_t;

    typedef enum logic [2:0] {
        PH_MAP  = 3'd0,
        PH_ENT  = 3'd1,
        PH_PAT0 = 3'd2,
        PH_PAT1 = 3'd3,
        PH_HI   = 3'd4,
        PH_LOAD = 3'd7
    } phase_e;

    function automatic logic [IDX_W-1:0] pick_index(tile_row_t r, logic [FINE_W-1:0] b);
        return {r.p3[b], r.p2[b], r.p1[b], r.p0[b]};
    endfunction

    function automatic logic [COORD_W-1:0] wrap_line(logic [COORD_W-1:0] ln,
                                                     logic [COORD_W-1:0] sy);
        logic [COORD_W:0] s;
        s = {1'b0, ln} + {1'b0, sy};
        if (s >= (COORD_W+1)'(V_WRAP))
            s = s - (COORD_W+1)'(V_WRAP);
        return s[COORD_W-1:0];
    endfunction

endpackage

// File: rtl/bg_fetch.sv
module bg_fetch
    import bg_pkg::*;
#(
    parameter int VRAM_AW = 13,
    parameter logic [VRAM_AW-1:0] MAP_BASE = 13'h1C00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_start,
    input  logic [COORD_W-1:0]  line_num,
    input  logic [COORD_W-1:0]  scroll_x,
    input  logic [COORD_W-1:0]  scroll_y,
    input  logic                mask_left,
    output logic                vram_rd_en,
    output logic [VRAM_AW-1:0]  vram_addr,
    input  logic [WORD_W-1:0]   vram_rdata,
    output logic                run,
    output logic [SLOT_W-1:0]   slot,
    output logic [FINE_W-1:0]   phase,
    output logic                tile_load,
    output tile_row_t           fetched_row,
    output map_ent_t            fetched_ent,
    output logic [FINE_W-1:0]   fx0,
    output logic                mask_q
);

    logic [COORD_W-1:0] vy_next;
    logic [COORD_W-1:0] negx_next;
    logic [ROW_W-1:0]   row_q;
    logic [FINE_W-1:0]  fine_y_q;
    logic [COL_W-1:0]   col0_q;
    map_ent_t           ent_q;
    logic [WORD_W-1:0]  pw0_q;
    logic [WORD_W-1:0]  pw1_q;

    logic [COL_W-1:0]   col_cur;
    logic [FINE_W-1:0]  trow;
    logic [VRAM_AW-1:0] map_addr;
    logic [VRAM_AW-1:0] pat_addr;
    logic               fetch_slot;

    always_comb begin
        vy_next   = wrap_line(line_num, scroll_y);
        negx_next = COORD_W'(0) - scroll_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            slot     <= '0;
            phase    <= '0;
            row_q    <= '0;
            fine_y_q <= '0;
            col0_q   <= '0;
            fx0      <= '0;
            mask_q   <= 1'b0;
        end else if (!run) begin
            if (line_start) begin
                run      <= 1'b1;
                slot     <= '0;
                phase    <= '0;
                row_q    <= vy_next[COORD_W-1:FINE_W];
                fine_y_q <= vy_next[FINE_W-1:0];
                col0_q   <= negx_next[COORD_W-1:FINE_W];
                fx0      <= negx_next[FINE_W-1:0];
                mask_q   <= mask_left;
            end
        end else begin
            phase <= phase + 1'b1;
            if (phase == FINE_W'(PH_LOAD)) begin
                slot <= slot + 1'b1;
                if (slot == SLOT_W'(SLOT_LAST))
                    run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            pw0_q <= '0;
            pw1_q <= '0;
        end else if (run) begin
            case (phase)
                FINE_W'(PH_ENT):  ent_q <= map_ent_t'(vram_rdata);
                FINE_W'(PH_PAT1): pw0_q <= vram_rdata;
                FINE_W'(PH_HI):   pw1_q <= vram_rdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        col_cur    = col0_q + slot[COL_W-1:0];
        trow       = ent_q.vflip ? ~fine_y_q : fine_y_q;
        map_addr   = MAP_BASE + VRAM_AW'({row_q, col_cur});
        pat_addr   = VRAM_AW'({ent_q.tile, trow, (phase == FINE_W'(PH_PAT1))});
        fetch_slot = run && (slot <= SLOT_W'(TILES_VIS));
        vram_rd_en = fetch_slot && ((phase == FINE_W'(PH_MAP)) ||
                                    (phase == FINE_W'(PH_PAT0)) ||
                                    (phase == FINE_W'(PH_PAT1)));
        vram_addr  = (phase == FINE_W'(PH_MAP)) ? map_addr : pat_addr;
        tile_load  = run && (phase == FINE_W'(PH_LOAD));
        fetched_ent = ent_q;
        fetched_row = tile_row_t'({pw1_q, pw0_q});
    end

endmodule

// File: rtl/bg_shifter.sv
module bg_shifter
    import bg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  tile_row_t         row_in,
    input  map_ent_t          ent_in,
    input  logic [FINE_W-1:0] phase,
    output bg_pix_t           pix
);

    tile_row_t cur_row;
    logic      cur_hflip;
    logic      cur_pal;
    logic      cur_prio;
    logic [FINE_W-1:0] bit_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row   <= '0;
            cur_hflip <= 1'b0;
            cur_pal   <= 1'b0;
            cur_prio  <= 1'b0;
        end else if (load) begin
            cur_row   <= row_in;
            cur_hflip <= ent_in.hflip;
            cur_pal   <= ent_in.pal;
            cur_prio  <= ent_in.prio;
        end
    end

    always_comb begin
        bit_sel  = cur_hflip ? phase : ~phase;
        pix.idx  = pick_index(cur_row, bit_sel);
        pix.pal  = cur_pal;
        pix.prio = cur_prio;
    end

endmodule

// File: rtl/bg_cram.sv
module bg_cram
    import bg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               addr_we,
    input  logic               data_we,
    input  logic [7:0]         wdata,
    input  logic [CRAM_AW-1:0] rd_idx,
    output logic [RGB_W-1:0]   rd_rgb,
    output logic [CRAM_AW-1:0] ptr
);

    logic [RGB_W-1:0] mem [CRAM_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (addr_we) begin
            ptr <= wdata[CRAM_AW-1:0];
        end else if (data_we) begin
            ptr <= ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < CRAM_N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (data_we && !addr_we && (ptr == CRAM_AW'(i)))
                mem[i] <= wdata[RGB_W-1:0];
        end
    end

    assign rd_rgb = mem[rd_idx];

endmodule

// File: rtl/bg_render.sv
module bg_render
    import bg_pkg::*;
#(
    parameter int VRAM_AW = 13,
    parameter logic [VRAM_AW-1:0] MAP_BASE = 13'h1C00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_start,
    input  logic [7:0]          line_num,
    input  logic [7:0]          scroll_x,
    input  logic [7:0]          scroll_y,
    input  logic                mask_left,
    output logic                vram_rd_en,
    output logic [VRAM_AW-1:0]  vram_addr,
    input  logic [15:0]         vram_rdata,
    input  logic                cram_addr_we,
    input  logic                cram_data_we,
    input  logic [7:0]          cram_wdata,
    output logic                pix_valid,
    output logic [7:0]          pix_x,
    output logic [3:0]          pix_index,
    output logic                pix_pal,
    output logic                pix_prio,
    output logic [5:0]          pix_rgb
);

    localparam int K_W = SLOT_W + FINE_W;

    logic               run;
    logic [SLOT_W-1:0]  slot;
    logic [FINE_W-1:0]  phase;
    logic               tile_load;
    tile_row_t          fetched_row;
    map_ent_t           fetched_ent;
    logic [FINE_W-1:0]  fx0;
    logic               mask_q;
    bg_pix_t            pix;
    logic [CRAM_AW-1:0] cram_ptr;
    logic [CRAM_AW-1:0] look_idx;
    logic [RGB_W-1:0]   look_rgb;

    logic [SLOT_W-1:0]  slot_m1;
    logic [K_W-1:0]     k;
    logic [K_W-1:0]     kx;
    logic               in_win;
    logic               masked;

    bg_fetch #(.VRAM_AW(VRAM_AW), .MAP_BASE(MAP_BASE)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .line_num    (line_num),
        .scroll_x    (scroll_x),
        .scroll_y    (scroll_y),
        .mask_left   (mask_left),
        .vram_rd_en  (vram_rd_en),
        .vram_addr   (vram_addr),
        .vram_rdata  (vram_rdata),
        .run         (run),
        .slot        (slot),
        .phase       (phase),
        .tile_load   (tile_load),
        .fetched_row (fetched_row),
        .fetched_ent (fetched_ent),
        .fx0         (fx0),
        .mask_q      (mask_q)
    );

    bg_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (tile_load),
        .row_in (fetched_row),
        .ent_in (fetched_ent),
        .phase  (phase),
        .pix    (pix)
    );

    bg_cram u_cram (
        .clk     (clk),
        .rst     (rst),
        .addr_we (cram_addr_we),
        .data_we (cram_data_we),
        .wdata   (cram_wdata),
        .rd_idx  (look_idx),
        .rd_rgb  (look_rgb),
        .ptr     (cram_ptr)
    );

    always_comb begin
        slot_m1  = slot - 1'b1;
        k        = {slot_m1, phase};
        kx       = k - K_W'(fx0);
        in_win   = run && (slot != '0) && (k >= K_W'(fx0)) && (kx < K_W'(SCREEN_W));
        masked   = mask_q && (kx < K_W'(TILE_PX));
        look_idx = masked ? BACKDROP : {pix.pal, pix.idx};
    end

    always_ff @(posedge clk) begin
        if (rst || !in_win) begin
            pix_valid <= 1'b0;
            pix_x     <= '0;
            pix_index <= '0;
            pix_pal   <= 1'b0;
            pix_prio  <= 1'b0;
            pix_rgb   <= '0;
        end else begin
            pix_valid <= 1'b1;
            pix_x     <= kx[COORD_W-1:0];
            pix_index <= look_idx[IDX_W-1:0];
            pix_pal   <= look_idx[CRAM_AW-1];
            pix_prio  <= masked ? 1'b0 : pix.prio;
            pix_rgb   <= look_rgb;
        end
    end

endmodule

// File: rtl/bg_render_chk.sv
module bg_render_chk (
    input logic       clk,
    input logic       rst,
    input logic       pix_valid,
    input logic [7:0] pix_x,
    input logic [3:0] pix_index,
    input logic       pix_pal,
    input logic       pix_prio,
    input logic       mask_q,
    input logic       cram_addr_we,
    input logic       cram_data_we,
    input logic [7:0] cram_wdata,
    input logic [4:0] ptr
);

    // R2: the line starts at column 0
    a_r2_first_x_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid) |-> pix_x == 8'd0);

    // R2: consecutive pixels advance the column by one
    a_r2_x_steps: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |-> pix_x == $past(pix_x) + 8'd1);

    // R9: masked column carries the backdrop fields
    a_r9_mask_backdrop: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mask_q && pix_x < 8'd8) |-> (pix_index == 4'd0 && pix_pal && !pix_prio));

    // R10: data write advances the pointer with wrap
    a_r10_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        (cram_data_we && !cram_addr_we) |=> ptr == $past(ptr) + 5'd1);

    // R10: pointer load takes the low five bits
    a_r10_ptr_load: assert property (@(posedge clk) disable iff (rst)
        cram_addr_we |=> ptr == $past(cram_wdata[4:0]));

endmodule

bind bg_render bg_render_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_valid    (pix_valid),
    .pix_x        (pix_x),
    .pix_index    (pix_index),
    .pix_pal      (pix_pal),
    .pix_prio     (pix_prio),
    .mask_q       (mask_q),
    .cram_addr_we (cram_addr_we),
    .cram_data_we (cram_data_we),
    .cram_wdata   (cram_wdata),
    .ptr          (cram_ptr)
);

// File: tb/bg_render_test.sv
module bg_render_test;

    localparam int MAPB = 'h1C00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic [7:0]  line_num = '0;
    logic [7:0]  scroll_x = '0;
    logic [7:0]  scroll_y = '0;
    logic        mask_left = 1'b0;
    logic        vram_rd_en;
    logic [12:0] vram_addr;
    logic [15:0] vram_rdata = '0;
    logic        cram_addr_we = 1'b0;
    logic        cram_data_we = 1'b0;
    logic [7:0]  cram_wdata = '0;
    logic        pix_valid;
    logic [7:0]  pix_x;
    logic [3:0]  pix_index;
    logic        pix_pal;
    logic        pix_prio;
    logic [5:0]  pix_rgb;

    logic [15:0] mem [8192];
    int          cmodel [32];
    int          cptr = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    bg_render uut (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .scroll_x(scroll_x), .scroll_y(scroll_y), .mask_left(mask_left),
        .vram_rd_en(vram_rd_en), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .cram_addr_we(cram_addr_we), .cram_data_we(cram_data_we), .cram_wdata(cram_wdata),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_index(pix_index),
        .pix_pal(pix_pal), .pix_prio(pix_prio), .pix_rgb(pix_rgb)
    );

    always @(posedge clk) if (vram_rd_en) vram_rdata <= mem[vram_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Reference: {prio,pal,idx} for screen pixel x (R3, R4, R5, R6, R7, R9)
    function automatic int exp_pix(int ln, int sx, int sy, bit m, int x);
        int mx, vy, e, t, r, w0, w1, b, idx;
        if (m && x < 8) return 16;
        mx = (x - sx + 256) % 256;
        vy = (ln + sy) % 224;
        e  = int'(mem[MAPB + (vy / 8) * 32 + mx / 8]);
        t  = e & 511;
        r  = vy % 8;
        if (((e >> 10) & 1) == 1) r = 7 - r;
        w0 = int'(mem[t * 16 + r * 2]);
        w1 = int'(mem[t * 16 + r * 2 + 1]);
        b  = (((e >> 9) & 1) == 1) ? (mx % 8) : (7 - mx % 8);
        idx = (((w1 >> (8 + b)) & 1) << 3) | (((w1 >> b) & 1) << 2) |
              (((w0 >> (8 + b)) & 1) << 1) | ((w0 >> b) & 1);
        return (((e >> 12) & 1) << 5) | (((e >> 11) & 1) << 4) | idx;
    endfunction

    task automatic cram_addr(input int a);
        @(negedge clk);
        cram_addr_we = 1'b1; cram_wdata = 8'(a);
        @(negedge clk);
        cram_addr_we = 1'b0;
        cptr = a & 31;
    endtask

    task automatic cram_put(input int d);
        @(negedge clk);
        cram_data_we = 1'b1; cram_wdata = 8'(d);
        @(negedge clk);
        cram_data_we = 1'b0;
        cmodel[cptr] = d & 63;
        cptr = (cptr + 1) % 32;
    endtask

    // One scanline; wc = cycle of a mid-line colour write (R11), rc = cycle of a stray line_start (R12)
    task automatic run_line(input int ln, input int sx, input int sy, input bit m,
                            input int wc, input int wval, input int rc);
        int fx0, e, qx;
        int q[$];
        fx0 = (256 - sx) % 8;
        for (int x = 0; x < 256; x++) q.push_back(exp_pix(ln, sx, sy, m, x));
        @(negedge clk);
        line_num = 8'(ln); scroll_x = 8'(sx); scroll_y = 8'(sy); mask_left = m;
        line_start = 1'b1;
        @(posedge clk);
        for (int j = 0; j < 282; j++) begin
            bit ev;
            @(negedge clk);
            if (j == 0) line_start = 1'b0;
            ev = (j >= 9 + fx0) && (j < 265 + fx0);
            chk(pix_valid === ev, "R2 valid", int'(pix_valid), int'(ev));
            if (ev && pix_valid === 1'b1) begin
                qx = j - 9 - fx0;
                e  = q.pop_front();
                chk(pix_x == 8'(qx), "R2 x", int'(pix_x), qx);
                if (m && qx < 8) begin
                    chk({pix_prio, pix_pal, pix_index} == 6'(e), "R9 mask",
                        int'({pix_prio, pix_pal, pix_index}), e);
                end else begin
                    chk(pix_index == 4'(e & 15), "R5 R6 R7 index", int'(pix_index), e & 15);
                    chk(pix_pal == e[4], "R4 pal", int'(pix_pal), (e >> 4) & 1);
                    chk(pix_prio == e[5], "R4 prio", int'(pix_prio), (e >> 5) & 1);
                end
                chk(int'(pix_rgb) == cmodel[e & 31], "R8 R11 rgb", int'(pix_rgb), cmodel[e & 31]);
            end
            if (j == wc) begin
                cram_data_we = 1'b1; cram_wdata = 8'(wval);
            end
            if (j == wc + 1) begin
                cram_data_we = 1'b0;
                cmodel[cptr] = wval & 63;
                cptr = (cptr + 1) % 32;
            end
            if (j == rc) begin
                line_start = 1'b1; scroll_x = 8'(sx + 77); scroll_y = 8'(sy + 13);
                line_num = 8'(ln ^ 8'h55); mask_left = ~m;
            end
            if (j == rc + 1) line_start = 1'b0;
        end
    endtask

    initial begin
        int seed;
        seed = 32'h1234_5678;
        for (int i = 0; i < 8192; i++) begin
            seed = seed * 1103515245 + 12345;
            mem[i] = 16'(seed >>> 9);
        end
        for (int i = 0; i < 32; i++) cmodel[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state of all outputs
        chk(pix_valid == 1'b0, "R1 valid", int'(pix_valid), 0);
        chk({pix_x, pix_index, pix_pal, pix_prio, pix_rgb} == '0, "R1 fields",
            int'({pix_x, pix_index, pix_pal, pix_prio, pix_rgb}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pix_valid == 1'b0, "R1 valid after", int'(pix_valid), 0);
        // R1 pointer at 0, R10 bits 7:6 dropped: fill 32 entries without a pointer load
        for (int i = 0; i < 32; i++) cram_put(((i * 37 + 5) & 63) | ((i & 3) << 6));
        // R3 R6 R7 plain line, no scroll
        run_line(0, 0, 0, 1'b0, -10, 0, -10);
        // R3 scroll wrap at 224 with mask (R9)
        run_line(150, 3, 100, 1'b1, -10, 0, -10);
        run_line(191, 255, 223, 1'b0, -10, 0, -10);
        run_line(97, 130, 240, 1'b1, -10, 0, -10);
        // R10 pointer wrap 31 -> 0
        cram_addr(8'hFF);
        cram_put(8'hEA);
        cram_put(8'h53);
        run_line(12, 9, 60, 1'b0, -10, 0, -10);
        // R11 write colliding with the lookup of pixel x=40
        begin
            int tgt;
            tgt = exp_pix(33, 21, 5, 1'b0, 40) & 31;
            cram_addr(tgt);
            run_line(33, 21, 5, 1'b0, 40 + 8 + (256 - 21) % 8, (cmodel[tgt] ^ 63) | 8'h80, -10);
        end
        // R12 stray line_start mid-line with changed inputs
        run_line(70, 44, 17, 1'b1, -10, 0, 120);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule